// File: doc/BRIEF.md
# Transmit/Receive Event Timestamp Capture

This block samples a free-running nanosecond counter when a timing event fires on the transmit or receive path. Each direction owns one capture slot. A slot holds a 64-bit stamp that software reads as two 32-bit words through a small register read port.

Once a slot has captured an event, it locks. It ignores every later event in that direction until software reads the stamp's upper word. That read frees the slot, so a stamp can always be tied to exactly one packet.

Receive events can instead use an in-band mode. Here the stamp is not parked in the register slot. It is sent out as a four-word header stream that downstream logic writes ahead of the packet data. This mode stamps every receive event whatever the receive enable says.

Top module: `evt_stamp_latch`

## Requirements
- R1: An event arriving while its direction's enable input is low is not captured. The valid flag, bit 0 of the control word at read address 0 (transmit) or 4 (receive), stays 0.
- R2: An enabled event arriving at an empty slot sets that slot's valid flag after the clock edge. The stamp becomes the counter value from the event cycle, zero-extended to 64 bits. Bits 31:0 read at address 1 (transmit) or 5 (receive), and bits 63:32 at address 2 (transmit) or 6 (receive).
- R3: While a slot is valid, further events in that direction leave both stamp words and the valid flag unchanged.
- R4: A read strobe at the upper-word address (2 or 6) clears that slot's valid flag, and a later event is then captured. A read of the lower-word address leaves valid set.
- R5: If an event and an upper-word read of the same direction meet in one cycle, the read wins. The event is dropped and valid is 0 afterwards.
- R6: The two directions are independent: an event, enable or read in one direction never changes the other direction's slot.
- R7: With in-band mode high, a receive event starts a header burst on the four cycles after the event edge. The words are 0, 0, stamp bits 31:0, stamp bits 63:32. The header-valid output acts as the stamp-present flag, with first and last markers on words 0 and 3.
- R8: In in-band mode a receive event produces a header even when the receive enable is low, and the receive register slot stays empty.
- R9: A receive event arriving while a header burst is still running is dropped; the running burst completes unchanged.
- R10: After reset both valid flags are 0 and no header word is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_ns | input | CNT_W | Live nanosecond counter |
| tx_event | input | 1 | Transmit timing event strobe |
| rx_event | input | 1 | Receive timing event strobe |
| tx_enable | input | 1 | Transmit capture enable |
| rx_enable | input | 1 | Receive capture enable |
| rx_inband | input | 1 | Receive stamps go to the in-band header |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| hdr_valid | output | 1 | Header word present / stamp-in-header flag |
| hdr_first | output | 1 | Header word 0 |
| hdr_last | output | 1 | Header word 3 |
| hdr_data | output | 32 | Header word |

## Verification
The bench goes after the lock. A design that overwrote a full slot would return the second event's time instead of the first. It also checks that reading the lower word does not release the slot; a design that got this wrong would let a second packet steal the stamp. The same-cycle collision of an event and an upper-word read is driven in both the empty and the full state; a design that let the event win would report valid afterwards. Header bursts are sampled word by word, including an event landing mid-burst, which a faulty design would use to restart or corrupt the header.

// File: rtl/evt_stamp_latch.sv
module evt_stamp_latch #(
  parameter int CNT_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] time_ns,
  input  logic             tx_event,
  input  logic             rx_event,
  input  logic             tx_enable,
  input  logic             rx_enable,
  input  logic             rx_inband,
  input  logic             rd_en,
  input  logic [2:0]       rd_addr,
  output logic [31:0]      rd_data,
  output logic             hdr_valid,
  output logic             hdr_first,
  output logic             hdr_last,
  output logic [31:0]      hdr_data
);
  localparam int PAD = 64 - CNT_W;

  logic        tx_valid, rx_valid;
  logic [63:0] tx_stamp, rx_stamp, hdr_stamp;
  logic [2:0]  hdr_cnt;
  logic [63:0] now_stamp;
  logic        tx_hi_rd, rx_hi_rd, tx_cap, rx_cap, hdr_start;

  assign now_stamp = {{PAD{1'b0}}, time_ns};
  assign tx_hi_rd  = rd_en && (rd_addr == 3'd2);
  assign rx_hi_rd  = rd_en && (rd_addr == 3'd6);
  assign tx_cap    = tx_event && tx_enable && !tx_valid && !tx_hi_rd;
  assign rx_cap    = rx_event && rx_enable && !rx_inband && !rx_valid && !rx_hi_rd;
  assign hdr_start = rx_event && rx_inband && (hdr_cnt == 3'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_stamp <= '0;
    end else if (tx_hi_rd) begin
      tx_valid <= 1'b0;
    end else if (tx_cap) begin
      tx_valid <= 1'b1;
      tx_stamp <= now_stamp;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_stamp <= '0;
    end else if (rx_hi_rd) begin
      rx_valid <= 1'b0;
    end else if (rx_cap) begin
      rx_valid <= 1'b1;
      rx_stamp <= now_stamp;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hdr_cnt   <= 3'd0;
      hdr_stamp <= '0;
    end else if (hdr_start) begin
      hdr_cnt   <= 3'd1;
      hdr_stamp <= now_stamp;
    end else if (hdr_cnt == 3'd4) begin
      hdr_cnt   <= 3'd0;
    end else if (hdr_cnt != 3'd0) begin
      hdr_cnt   <= hdr_cnt + 3'd1;
    end
  end

  assign hdr_valid = (hdr_cnt != 3'd0);
  assign hdr_first = (hdr_cnt == 3'd1);
  assign hdr_last  = (hdr_cnt == 3'd4);
  assign hdr_data  = (hdr_cnt == 3'd3) ? hdr_stamp[31:0] :
                     (hdr_cnt == 3'd4) ? hdr_stamp[63:32] : 32'd0;

  always_comb begin
    case (rd_addr)
      3'd0:    rd_data = {30'd0, tx_enable, tx_valid};
      3'd1:    rd_data = tx_stamp[31:0];
      3'd2:    rd_data = tx_stamp[63:32];
      3'd4:    rd_data = {29'd0, rx_inband, rx_enable, rx_valid};
      3'd5:    rd_data = rx_stamp[31:0];
      3'd6:    rd_data = rx_stamp[63:32];
      default: rd_data = 32'd0;
    endcase
  end

  // R1
  a_r1_tx_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_valid && !tx_enable) |=> !tx_valid);
  // R2
  a_r2_tx_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_event && tx_enable && !tx_valid && !rd_en) |=>
      (tx_valid && tx_stamp == {{PAD{1'b0}}, $past(time_ns)}));
  // R3
  a_r3_tx_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_hi_rd) |=> (tx_valid && $stable(tx_stamp)));
  a_r3_rx_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_hi_rd) |=> (rx_valid && $stable(rx_stamp)));
  // R4, R5
  a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == 3'd6) |=> !rx_valid);
  // R8
  a_r8_inband_no_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_inband && !rx_valid) |=> !rx_valid);
  // R7
  a_r7_hdr_order: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_first |=> (hdr_valid && !hdr_first && hdr_data == 32'd0));
  // R9
  a_r9_burst_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && !hdr_last) |=> (hdr_valid && !hdr_first && $stable(hdr_stamp)));
endmodule

// File: tb/test_evt_stamp_latch.sv
module test_evt_stamp_latch;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [39:0] time_ns = '0;
  logic        tx_event = 0, rx_event = 0, tx_enable = 0, rx_enable = 0, rx_inband = 0;
  logic        rd_en = 0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data, hdr_data;
  logic        hdr_valid, hdr_first, hdr_last;
  int checks = 0, failures = 0;
  bit done = 0;

  evt_stamp_latch #(.CNT_W(40)) i_evt_stamp_latch (
    .clk(clk), .rst_n(rst_n), .time_ns(time_ns), .tx_event(tx_event), .rx_event(rx_event),
    .tx_enable(tx_enable), .rx_enable(rx_enable), .rx_inband(rx_inband),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .hdr_valid(hdr_valid), .hdr_first(hdr_first), .hdr_last(hdr_last), .hdr_data(hdr_data));

  always #4 clk = ~clk;

  // bit 40 = direction (1 = receive), bits 39:0 = counter value
  localparam logic [40:0] VEC [8] = '{
    {1'b0, 40'h00_0000_0001}, {1'b1, 40'h00_FFFF_FFFF}, {1'b0, 40'hFF_FFFF_FFFF},
    {1'b1, 40'h12_3456_789A}, {1'b0, 40'h80_0000_0000}, {1'b1, 40'h01_0000_0000},
    {1'b0, 40'h5A_A55A_A55A}, {1'b1, 40'h00_0000_0000}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // peek: read without strobe side effects
  task automatic peek(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 0; rd_addr = a; #1 d = rd_data;
  endtask

  // strobed read, takes effect at next posedge
  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; rd_addr = a; #1 d = rd_data;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic ev(input bit rx, input logic [39:0] t);
    @(negedge clk); time_ns = t; if (rx) rx_event = 1; else tx_event = 1;
    @(negedge clk); tx_event = 0; rx_event = 0; time_ns = t + 40'd77;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10 reset state
    peek(3'd0, d); chk("R10 tx valid", d[0], 0);
    peek(3'd4, d); chk("R10 rx valid", d[0], 0);
    #1 chk("R10 hdr idle", hdr_valid, 0);

    tx_enable = 1; rx_enable = 1;
    // R2/R4 vector table
    foreach (VEC[i]) begin
      logic [2:0] base;
      base = VEC[i][40] ? 3'd4 : 3'd0;
      ev(VEC[i][40], VEC[i][39:0]);
      peek(base, d);            chk("R2 valid set", d[0], 1);
      rd(base + 3'd1, d);       chk("R2 low word", d, VEC[i][31:0]);
      peek(base, d);            chk("R4 low read keeps valid", d[0], 1);
      rd(base + 3'd2, d);       chk("R2 high word", d, {24'd0, VEC[i][39:32]});
      peek(base, d);            chk("R4 high read clears valid", d[0], 0);
    end

    // R3 lock
    ev(0, 40'h11_2222_3333);
    ev(0, 40'h44_5555_6666);
    peek(3'd1, d); chk("R3 tx low kept", d, 32'h2222_3333);
    peek(3'd2, d); chk("R3 tx high kept", d, 32'h11);
    // R6 rx slot untouched by tx
    peek(3'd4, d); chk("R6 rx idle while tx full", d[0], 0);
    ev(1, 40'h00_0000_0ABC);
    peek(3'd1, d); chk("R6 tx unchanged by rx event", d, 32'h2222_3333);
    rd(3'd6, d);
    peek(3'd0, d); chk("R6 tx still valid after rx release", d[0], 1);
    rd(3'd2, d);

    // R1 disabled
    tx_enable = 0;
    ev(0, 40'h7);
    peek(3'd0, d); chk("R1 tx disabled not captured", d[0], 0);
    tx_enable = 1;
    rx_enable = 0;
    ev(1, 40'h9);
    peek(3'd4, d); chk("R1 rx disabled not captured", d[0], 0);
    rx_enable = 1;

    // R5 collision, empty slot
    @(negedge clk); tx_event = 1; time_ns = 40'h33; rd_en = 1; rd_addr = 3'd2;
    @(negedge clk); tx_event = 0; rd_en = 0;
    peek(3'd0, d); chk("R5 event dropped at empty slot", d[0], 0);
    // R5 collision, full slot
    ev(0, 40'h44);
    @(negedge clk); tx_event = 1; time_ns = 40'h55; rd_en = 1; rd_addr = 3'd2;
    @(negedge clk); tx_event = 0; rd_en = 0;
    peek(3'd0, d); chk("R5 read wins on full slot", d[0], 0);
    ev(0, 40'h66);
    peek(3'd1, d); chk("R4 capture after release", d, 32'h66);
    rd(3'd2, d);

    // R7/R8 in-band header, rx_enable low
    rx_inband = 1; rx_enable = 0;
    @(negedge clk); rx_event = 1; time_ns = 40'hAB_CDEF_0123;
    @(negedge clk); rx_event = 0;
    #1;
    chk("R7 word0 valid", hdr_valid, 1); chk("R7 word0 first", hdr_first, 1); chk("R7 word0 data", hdr_data, 0);
    @(negedge clk); #1 chk("R7 word1 data", hdr_data, 0);
    rx_event = 1; time_ns = 40'h99_9999_9999; // R9 mid-burst event
    @(negedge clk); rx_event = 0; #1
    chk("R7 word2 low stamp", hdr_data, 32'hCDEF_0123);
    chk("R9 no restart", hdr_first, 0);
    @(negedge clk); #1
    chk("R7 word3 high stamp", hdr_data, 32'hAB);
    chk("R7 word3 last", hdr_last, 1);
    @(negedge clk); #1 chk("R9 burst ends, no second header", hdr_valid, 0);
    peek(3'd4, d); chk("R8 rx slot empty in in-band mode", d[0], 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule